// File: doc/BRIEF.md
# Doorbell Message Register Bank

This block is the software-facing side of a short-message ("doorbell") service at a packet interconnect endpoint. A 32-bit memory-mapped slave exposes ten word-spaced registers. Software posts outbound messages (target device ID plus a 16-bit information field) into a transmit queue. The block hands them to the link side through a valid/ready handshake. It counts the messages that have gone out and still await a response. As responses come back, it records their outcome in a completion queue, with a per-outcome filter.

Inbound messages arrive through a valid/ready handshake and are queued for software. Software pops them by reading one register. A three-source interrupt status register with matching enables drives a single interrupt line. The overflow source cannot be cleared until software has consumed at least one completion entry.

All queue depths come from one parameter `DEPTH` (16 by default). Register reads are combinational: `reg_rdata_o` is valid in the same cycle as `reg_rd_i`. Any pop or state change caused by the read takes effect at the following clock edge.

Top module: `db_regbank`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Offset 0x00 returns the oldest received message and removes it. The message word holds the upper device-ID byte in [31:24], the device ID in [23:16] and the information field in [15:0]. It is passed through unchanged from `rx_msg_i`.
- R3: The receive queue holds up to `DEPTH` messages. Offset 0x04 bits [7:0] give its fill. While it is full, `rx_ready_o` is low and new messages are not taken.
- R4: Offset 0x08 bits [1:0] set the request priority driven on `tx_prio_o`. A write of 2'b11 is stored as 2'b10.
- R5: A write to 0x0C queues the word as an outbound message. `tx_valid_o`/`tx_msg_o` present the oldest one, and each valid-and-ready cycle moves it to the awaiting-response count. That count is offset 0x10 [23:16], and the queue fill is 0x10 [15:8]. While `DEPTH` messages await a response, `tx_valid_o` stays low.
- R6: A write to 0x0C while the transmit queue holds `DEPTH` messages is ignored. The queue fill is unchanged, and 0x0C reads back the last accepted word.
- R7: Each `rsp_valid_i` cycle decrements the awaiting count, saturating at zero. The outcome code is 00 done, 01 error, 10 time-out. The response is stored in the completion queue only if offset 0x1C bit 0 is set (for done) or bit 1 is set (for error and time-out). The completion fill is 0x10 [7:0].
- R8: Reading 0x14 pops the oldest completion word, and 0x18 [1:0] then gives its outcome code. Reading 0x00 or 0x14 while that queue is empty returns zero and changes no state.
- R9: Interrupt status at 0x24 has bit 0 for a message received, bit 1 for a completion stored and bit 2 for completion overflow. Bit 0 and bit 1 clear on a write of 1.
- R10: A response that passes the filter while the completion queue is full is dropped and sets status bit 2. A write of 1 to bit 2 has no effect until a completion entry has been read after the overflow. The queue need not be drained.
- R11: `irq_o` is high exactly when a status bit and its enable bit at 0x20 (same bit order) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops queues) |
| reg_addr_i | input | 6 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, same cycle |
| rx_valid_i | input | 1 | Inbound message valid |
| rx_msg_i | input | 32 | Inbound message word |
| rx_ready_o | output | 1 | Receive queue can accept |
| tx_valid_o | output | 1 | Outbound message valid |
| tx_msg_o | output | 32 | Outbound message word |
| tx_prio_o | output | 2 | Outbound request priority |
| tx_ready_i | input | 1 | Link side accepts outbound message |
| rsp_valid_i | input | 1 | Response received |
| rsp_code_i | input | 2 | Response outcome code |
| rsp_msg_i | input | 32 | Message word the response belongs to |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the bank with `DEPTH` = 4. With that depth, a handful of operations fills the receive queue, fills the transmit queue, and saturates the awaiting-response count so that sending stops. It also lets the completion queue overflow after only five responses. The full and overflow corners can then be checked next to the ordinary paths, including the lock on the overflow bit before and after a completion read.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned MSG_W  = 32;

  typedef enum logic [1:0] {
    CPL_DONE    = 2'b00,
    CPL_ERR     = 2'b01,
    CPL_TIMEOUT = 2'b10
  } cpl_code_e;

  // word index = byte address [5:2]
  localparam logic [3:0] IDX_RX_MSG   = 4'd0;
  localparam logic [3:0] IDX_RX_STAT  = 4'd1;
  localparam logic [3:0] IDX_TX_CTRL  = 4'd2;
  localparam logic [3:0] IDX_TX_MSG   = 4'd3;
  localparam logic [3:0] IDX_TX_STAT  = 4'd4;
  localparam logic [3:0] IDX_CPL_MSG  = 4'd5;
  localparam logic [3:0] IDX_CPL_STAT = 4'd6;
  localparam logic [3:0] IDX_CPL_CTRL = 4'd7;
  localparam logic [3:0] IDX_IRQ_EN   = 4'd8;
  localparam logic [3:0] IDX_IRQ_STS  = 4'd9;

  localparam int unsigned IRQ_RX  = 0;
  localparam int unsigned IRQ_CPL = 1;
  localparam int unsigned IRQ_OVF = 2;
  localparam int unsigned IRQ_N   = 3;
endpackage

// File: rtl/db_fifo.sv
module db_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = empty_o ? '0 : mem_q[rptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/db_irq.sv
module db_irq
  import db_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_rx_i,
  input  logic             set_cpl_i,
  input  logic             set_ovf_i,
  input  logic             cpl_pop_i,
  input  logic             clr_wr_i,
  input  logic [IRQ_N-1:0] clr_mask_i,
  input  logic [IRQ_N-1:0] enable_i,
  output logic [IRQ_N-1:0] status_o,
  output logic             irq_o
);
  logic [IRQ_N-1:0] sts_q;
  logic             unlock_q;
  logic [IRQ_N-1:0] clr;

  assign clr = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q    <= '0;
      unlock_q <= 1'b0;
    end else begin
      // a new overflow re-arms the lock; a completion read releases it
      if (set_ovf_i)                       unlock_q <= 1'b0;
      else if (cpl_pop_i && sts_q[IRQ_OVF]) unlock_q <= 1'b1;
      sts_q[IRQ_RX]  <= set_rx_i  | (sts_q[IRQ_RX]  & ~clr[IRQ_RX]);
      sts_q[IRQ_CPL] <= set_cpl_i | (sts_q[IRQ_CPL] & ~clr[IRQ_CPL]);
      sts_q[IRQ_OVF] <= set_ovf_i | (sts_q[IRQ_OVF] & ~(clr[IRQ_OVF] & unlock_q));
    end
  end

  assign status_o = sts_q;
  assign irq_o    = |(sts_q & enable_i);
endmodule

// File: rtl/db_regbank.sv
module db_regbank
  import db_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              rx_valid_i,
  input  logic [MSG_W-1:0]  rx_msg_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [MSG_W-1:0]  tx_msg_o,
  output logic [1:0]        tx_prio_o,
  input  logic              tx_ready_i,
  input  logic              rsp_valid_i,
  input  logic [1:0]        rsp_code_i,
  input  logic [MSG_W-1:0]  rsp_msg_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned CPL_W = MSG_W + 2;

  logic [3:0] idx;
  logic       aligned, wr, rd;
  assign idx     = reg_addr_i[REG_AW-1:2];
  assign aligned = (reg_addr_i[1:0] == 2'b00);
  assign wr      = reg_wr_i && aligned;
  assign rd      = reg_rd_i && aligned;

  // receive queue
  logic             rx_full, rx_empty, rx_pop;
  logic [MSG_W-1:0] rx_head;
  logic [CNT_W-1:0] rx_level;
  assign rx_ready_o = !rx_full;
  assign rx_pop     = rd && (idx == IDX_RX_MSG);

  db_fifo #(.WIDTH(MSG_W), .DEPTH(DEPTH)) u_rx_q (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .data_i(rx_msg_i),
    .pop_i(rx_pop), .data_o(rx_head),
    .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_level)
  );

  // transmit queue and awaiting-response count
  logic             tx_full, tx_empty, tx_push, tx_fire;
  logic [CNT_W-1:0] tx_level, pend_q;
  logic [MSG_W-1:0] tx_last_q;
  logic [1:0]       prio_q;
  assign tx_push    = wr && (idx == IDX_TX_MSG) && !tx_full;
  assign tx_valid_o = !tx_empty && (pend_q < CNT_W'(DEPTH));
  assign tx_fire    = tx_valid_o && tx_ready_i;
  assign tx_prio_o  = prio_q;

  db_fifo #(.WIDTH(MSG_W), .DEPTH(DEPTH)) u_tx_q (
    .clk_i, .rst_ni,
    .push_i(tx_push), .data_i(reg_wdata_i),
    .pop_i(tx_fire), .data_o(tx_msg_o),
    .full_o(tx_full), .empty_o(tx_empty), .level_o(tx_level)
  );

  logic rsp_dec;
  assign rsp_dec = rsp_valid_i && (pend_q != '0);

  // completion queue with outcome filter
  logic [1:0]       cpl_ctrl_q, last_code_q;
  logic             cpl_keep, cpl_full, cpl_empty, cpl_pop, ovf_evt;
  logic [CPL_W-1:0] cpl_head;
  logic [CNT_W-1:0] cpl_level;
  assign cpl_keep = rsp_valid_i &&
                    ((rsp_code_i == CPL_DONE) ? cpl_ctrl_q[0] : cpl_ctrl_q[1]);
  assign ovf_evt  = cpl_keep && cpl_full;
  assign cpl_pop  = rd && (idx == IDX_CPL_MSG) && !cpl_empty;

  db_fifo #(.WIDTH(CPL_W), .DEPTH(DEPTH)) u_cpl_q (
    .clk_i, .rst_ni,
    .push_i(cpl_keep), .data_i({rsp_code_i, rsp_msg_i}),
    .pop_i(cpl_pop), .data_o(cpl_head),
    .full_o(cpl_full), .empty_o(cpl_empty), .level_o(cpl_level)
  );

  // interrupts
  logic [IRQ_N-1:0] irq_en_q, irq_sts;
  db_irq u_irq (
    .clk_i, .rst_ni,
    .set_rx_i(rx_valid_i && !rx_full),
    .set_cpl_i(cpl_keep && !cpl_full),
    .set_ovf_i(ovf_evt),
    .cpl_pop_i(cpl_pop),
    .clr_wr_i(wr && (idx == IDX_IRQ_STS)),
    .clr_mask_i(reg_wdata_i[IRQ_N-1:0]),
    .enable_i(irq_en_q),
    .status_o(irq_sts),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q      <= '0;
      tx_last_q   <= '0;
      cpl_ctrl_q  <= '0;
      irq_en_q    <= '0;
      last_code_q <= '0;
      pend_q      <= '0;
    end else begin
      if (wr && idx == IDX_TX_CTRL)
        prio_q <= (reg_wdata_i[1:0] == 2'b11) ? 2'b10 : reg_wdata_i[1:0];
      if (tx_push)                   tx_last_q  <= reg_wdata_i;
      if (wr && idx == IDX_CPL_CTRL) cpl_ctrl_q <= reg_wdata_i[1:0];
      if (wr && idx == IDX_IRQ_EN)   irq_en_q   <= reg_wdata_i[IRQ_N-1:0];
      if (cpl_pop)                   last_code_q <= cpl_head[CPL_W-1 -: 2];
      pend_q <= pend_q + CNT_W'(tx_fire) - CNT_W'(rsp_dec);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      case (idx)
        IDX_RX_MSG:   reg_rdata_o = rx_head;
        IDX_RX_STAT:  reg_rdata_o = {24'd0, 8'(rx_level)};
        IDX_TX_CTRL:  reg_rdata_o = {30'd0, prio_q};
        IDX_TX_MSG:   reg_rdata_o = tx_last_q;
        IDX_TX_STAT:  reg_rdata_o = {8'd0, 8'(pend_q), 8'(tx_level), 8'(cpl_level)};
        IDX_CPL_MSG:  reg_rdata_o = cpl_head[MSG_W-1:0];
        IDX_CPL_STAT: reg_rdata_o = {30'd0, last_code_q};
        IDX_CPL_CTRL: reg_rdata_o = {30'd0, cpl_ctrl_q};
        IDX_IRQ_EN:   reg_rdata_o = {{(32-IRQ_N){1'b0}}, irq_en_q};
        IDX_IRQ_STS:  reg_rdata_o = {{(32-IRQ_N){1'b0}}, irq_sts};
        default:      reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/db_regbank_chk.sv
module db_regbank_chk
  import db_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_rd_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              rx_valid_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [1:0]        tx_prio_o,
  input logic              rsp_valid_i,
  input logic [CNT_W-1:0]  rx_level,
  input logic [CNT_W-1:0]  pend_q,
  input logic [CNT_W-1:0]  cpl_level,
  input logic [IRQ_N-1:0]  irq_sts
);
  logic seen_pop_q;
  logic cpl_rd;
  assign cpl_rd = reg_rd_i && (reg_addr_i == 6'h14) && (cpl_level != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seen_pop_q <= 1'b0;
    else if (!irq_sts[IRQ_OVF])      seen_pop_q <= 1'b0;
    else if (cpl_rd)                 seen_pop_q <= 1'b1;
  end

  assert_prio_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_prio_o != 2'b11);

  assert_rx_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level <= CNT_W'(DEPTH));

  assert_send_counts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !rsp_valid_i) |=> (pend_q == $past(pend_q) + 1'b1));

  assert_empty_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 6'h00 && rx_level == '0 && !rx_valid_i) |=> $stable(rx_level));

  assert_ovf_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sts[IRQ_OVF] && !seen_pop_q && !cpl_rd) |=> irq_sts[IRQ_OVF]);
endmodule

bind db_regbank db_regbank_chk #(.DEPTH(DEPTH)) u_db_regbank_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .rx_valid_i(rx_valid_i), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_prio_o(tx_prio_o), .rsp_valid_i(rsp_valid_i), .rx_level(rx_level),
  .pend_q(pend_q), .cpl_level(cpl_level), .irq_sts(irq_sts)
);

// File: tb/db_regbank_bench.sv
module db_regbank_bench;
  localparam int unsigned DEPTH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        rx_valid_i = 1'b0, rx_ready_o;
  logic [31:0] rx_msg_i = '0;
  logic        tx_valid_o, tx_ready_i = 1'b0;
  logic [31:0] tx_msg_o;
  logic [1:0]  tx_prio_o;
  logic        rsp_valid_i = 1'b0;
  logic [1:0]  rsp_code_i = '0;
  logic [31:0] rsp_msg_i = '0;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  db_regbank #(.DEPTH(DEPTH)) u_db_regbank (.*);

  typedef struct packed {
    logic        is_wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  // read entries compare against data; write entries apply data
  localparam vec_t VECS [12] = '{
    '{1'b1, 6'h08, 32'h3,        4'd4},  // R4 illegal priority
    '{1'b0, 6'h08, 32'h2,        4'd4},  // R4 coerced to 2'b10
    '{1'b1, 6'h08, 32'hFFFF_FFFD, 4'd4},
    '{1'b0, 6'h08, 32'h1,        4'd4},  // R4 upper bits dropped
    '{1'b1, 6'h1C, 32'hFFFF_FFFF, 4'd7},
    '{1'b0, 6'h1C, 32'h3,        4'd7},  // R7 filter bits
    '{1'b1, 6'h20, 32'h5,        4'd11},
    '{1'b0, 6'h20, 32'h5,        4'd11}, // R11 enable readback
    '{1'b1, 6'h1C, 32'h0,        4'd7},
    '{1'b0, 6'h1C, 32'h0,        4'd7},
    '{1'b1, 6'h20, 32'h0,        4'd11},
    '{1'b0, 6'h20, 32'h0,        4'd11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(posedge clk_i); #1;
    reg_rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic rx_push(input logic [31:0] m);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_msg_i = m;
    @(posedge clk_i); #1;
    rx_valid_i = 1'b0;
  endtask

  task automatic rsp(input logic [1:0] c, input logic [31:0] m);
    @(negedge clk_i);
    rsp_valid_i = 1'b1; rsp_code_i = c; rsp_msg_i = m;
    @(posedge clk_i); #1;
    rsp_valid_i = 1'b0;
  endtask

  task automatic tx_take(input int n);
    @(negedge clk_i);
    tx_ready_i = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 tx_ready_i = 1'b0;
  endtask

  task automatic port_chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk_i); #1;
    chk(req, act, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 10; i++) rd_chk("R1 reset reg", 6'(i * 4), 32'h0);
    port_chk("R1 irq", {31'd0, irq_o}, 32'h0);

    // register vectors
    for (int i = 0; i < 12; i++) begin
      if (VECS[i].is_wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, d);
        checks++;
        if (d !== VECS[i].data) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %h expected %h", VECS[i].req, i, d, VECS[i].data);
        end
      end
    end
    port_chk("R4 prio pin", {30'd0, tx_prio_o}, 32'h1);

    // receive path
    rx_push(32'hA1B2_C3D4);
    rx_push(32'h0055_1234);
    rd_chk("R3 rx fill", 6'h04, 32'd2);
    rd_chk("R9 rx status", 6'h24, 32'h1);
    port_chk("R11 irq masked", {31'd0, irq_o}, 32'h0);
    wr(6'h20, 32'h1);
    port_chk("R11 irq enabled", {31'd0, irq_o}, 32'h1);
    rd_chk("R2 rx head", 6'h00, 32'hA1B2_C3D4);
    rd_chk("R2 rx second", 6'h00, 32'h0055_1234);
    rd_chk("R8 rx empty read", 6'h00, 32'h0);
    rd_chk("R8 rx fill after empty read", 6'h04, 32'h0);
    wr(6'h24, 32'h1);
    rd_chk("R9 rx w1c", 6'h24, 32'h0);
    port_chk("R11 irq cleared", {31'd0, irq_o}, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) rx_push(32'h100 + i);
    port_chk("R3 rx_ready full", {31'd0, rx_ready_o}, 32'h0);
    rd_chk("R3 rx fill capped", 6'h04, DEPTH);
    for (int i = 0; i < DEPTH; i++) rd_chk("R2 rx order", 6'h00, 32'h100 + i);
    wr(6'h20, 32'h0);
    wr(6'h24, 32'h7);

    // transmit path
    wr(6'h0C, 32'h0101_0001);
    wr(6'h0C, 32'h0202_0002);
    wr(6'h0C, 32'h0303_0003);
    rd_chk("R5 tx fill", 6'h10, 32'h0000_0300);
    port_chk("R5 tx valid", {31'd0, tx_valid_o}, 32'h1);
    port_chk("R5 tx head", tx_msg_o, 32'h0101_0001);
    tx_take(1);
    rd_chk("R5 after send", 6'h10, 32'h0001_0200);
    port_chk("R5 next head", tx_msg_o, 32'h0202_0002);
    wr(6'h0C, 32'h0404_0004);
    wr(6'h0C, 32'h0505_0005);
    wr(6'h0C, 32'h0606_0006);
    rd_chk("R6 full write ignored", 6'h10, 32'h0001_0400);
    rd_chk("R6 readback last accepted", 6'h0C, 32'h0505_0005);
    tx_take(4);
    rd_chk("R5 pending cap", 6'h10, 32'h0004_0100);
    port_chk("R5 send held", {31'd0, tx_valid_o}, 32'h0);

    // responses and completion filter
    rsp(2'b00, 32'h0101_0001);
    rd_chk("R7 done discarded", 6'h10, 32'h0003_0100);
    wr(6'h1C, 32'h1);
    rsp(2'b01, 32'h0202_0002);
    rsp(2'b00, 32'h0303_0003);
    rd_chk("R7 done kept only", 6'h10, 32'h0001_0101);
    wr(6'h1C, 32'h2);
    rsp(2'b10, 32'h0404_0004);
    rd_chk("R7 timeout kept", 6'h10, 32'h0000_0102);
    rd_chk("R9 cpl status", 6'h24, 32'h2);
    rd_chk("R8 cpl head", 6'h14, 32'h0303_0003);
    rd_chk("R8 code done", 6'h18, 32'h0);
    rd_chk("R8 cpl next", 6'h14, 32'h0404_0004);
    rd_chk("R8 code timeout", 6'h18, 32'h2);
    rd_chk("R8 cpl empty read", 6'h14, 32'h0);
    rd_chk("R8 code kept", 6'h18, 32'h2);
    wr(6'h1C, 32'h3);
    rsp(2'b01, 32'h0202_0002);
    rd_chk("R8 err entry", 6'h14, 32'h0202_0002);
    rd_chk("R8 code error", 6'h18, 32'h1);

    // overflow lock
    wr(6'h24, 32'h7);
    rd_chk("R9 all cleared", 6'h24, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) rsp(2'b00, 32'hE000 + i);
    rd_chk("R10 overflow set", 6'h24, 32'h6);
    rd_chk("R10 cpl full", 6'h10, 32'h0000_0104);
    wr(6'h20, 32'h4);
    port_chk("R11 ovf irq", {31'd0, irq_o}, 32'h1);
    wr(6'h24, 32'h4);
    rd_chk("R10 clear locked", 6'h24, 32'h6);
    rd_chk("R10 oldest kept", 6'h14, 32'hE000);
    wr(6'h24, 32'h4);
    rd_chk("R10 clear after read", 6'h24, 32'h2);
    port_chk("R11 irq off", {31'd0, irq_o}, 32'h0);
    for (int i = 1; i < DEPTH; i++) rd_chk("R10 remaining", 6'h14, 32'hE000 + i);
    rd_chk("R10 dropped entry absent", 6'h14, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule